// File: doc/BRIEF.md
# I2C Master FIFO and Interrupt Register Front End

This block sits between a host register port and the bit-level engine of a packet-mode I2C master. It buffers outgoing words in a transmit queue and incoming words in a receive queue. Both queues are 32 bits wide and 8 words deep. The host sees a small register file. A control register holds the flush requests and the two trigger thresholds. A status register reports queue occupancy. An interrupt mask register and a write-one-to-clear interrupt status register complete the file.

The bus engine takes transmit words and hands back receive words over valid/ready handshakes. It reports transfer completion and bus errors on single-cycle pulse inputs. The status register gathers these events together with the host-side queue errors and two threshold-driven data requests. A single registered level interrupt is raised whenever any unmasked status bit is set.

Register select codes:
- 0: control
- 1: occupancy
- 2: mask
- 3: interrupt status
- 4: transmit data (write pushes)
- 5: receive data (read pops)

Top module: `i2c_fifo_irq_regs`

## Requirements
- R1: After reset the following hold.
  - The irq output is low and the mask register reads 0.
  - The occupancy register reads 0x80, meaning 8 free transmit slots and 0 receive words.
  - txValid is low and rxReady is high.
- R2: Words written to select 4 are presented on txData in write order. A word is removed only when txValid and txReady are both high. Occupancy bits 7:4 give the number of free transmit slots.
- R3: Words accepted from the engine while rxValid and rxReady are both high are returned in order by reads of select 5. Occupancy bits 3:0 give the number of stored receive words.
- R4: A write to select 4 while 8 words are held is dropped and never reaches txData. It sets interrupt status bit 5.
- R5: A read of select 5 while the receive queue is empty returns 0 and sets interrupt status bit 4.
- R6: Writing 1 to control bit 1 flushes the transmit queue, and writing 1 to control bit 0 flushes the receive queue.
  - A read issued in the cycle right after the write returns that bit as 1.
  - The bit reads 0 afterwards, and the queue is empty within two cycles.
  - Latched status bits survive the flush.
- R7: Control bits 7:5 hold the transmit trigger level and bits 4:2 hold the receive trigger level. Both read back as written.
- R8: Interrupt status bit 1 is high while the number of free transmit slots is at least the transmit trigger plus 1. Writing 1 to this bit has no effect.
- R9: Interrupt status bit 0 is high while the number of stored receive words is at least the receive trigger plus 1.
- R10: The event pulses latch into interrupt status bits as follows:
  - packet done sets bit 7
  - all packets done sets bit 6
  - no-acknowledge sets bit 3
  - arbitration lost sets bit 2
- R11: Writing select 3 clears each latched bit written as 1 and leaves bits written as 0 unchanged. Writing 0xFF clears every latched bit.
- R12: irq is a register that follows the OR of (status AND mask) one cycle later. A mask of 0 keeps irq low.
- R13: rxReady is low while the receive queue holds 8 words. An offered word is not stored while rxReady is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 3 | Register select for the host access |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe |
| wrData | input | 32 | Host write data |
| rdData | output | 32 | Host read data, registered, valid the cycle after rdEn |
| txValid | output | 1 | Transmit word available to the engine |
| txReady | input | 1 | Engine takes the transmit word |
| txData | output | 32 | Oldest transmit word |
| rxValid | input | 1 | Engine offers a receive word |
| rxReady | output | 1 | Receive queue can accept a word |
| rxData | input | 32 | Receive word from the engine |
| evPktDone | input | 1 | Packet transfer complete pulse |
| evAllDone | input | 1 | All packets complete pulse |
| evNack | input | 1 | No-acknowledge pulse |
| evArbLost | input | 1 | Arbitration lost pulse |
| irq | output | 1 | Level interrupt |

## Verification
The flush-in-progress state lasts a single cycle. To observe it, the stimulus issues a control read on the very cycle after the flush write. The same test confirms that the latched error bits survive while occupancy returns to empty.

The threshold requests depend on both fill level and trigger. The bench therefore sweeps every fill level from empty to full on both queues against all eight trigger values. The full-queue end of that sweep is also where the dropped transmit word and the refused receive word are provoked. The mask is swept over all 256 values against a known status pattern.

// File: rtl/i2c_fifo_pkg.sv
package i2c_fifo_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_OCC  = 3'd1,
    SEL_MASK = 3'd2,
    SEL_IRQ  = 3'd3,
    SEL_TXD  = 3'd4,
    SEL_RXD  = 3'd5
  } regSel_e;

  // interrupt status bit positions
  localparam int IB_PKT  = 7;
  localparam int IB_ALL  = 6;
  localparam int IB_OVF  = 5;
  localparam int IB_UDF  = 4;
  localparam int IB_NACK = 3;
  localparam int IB_ARB  = 2;
  localparam int IB_TXRQ = 1;
  localparam int IB_RXRQ = 0;
  localparam int NIRQ    = 8;

  // control bit positions
  localparam int CB_RXFL = 0;
  localparam int CB_TXFL = 1;
  localparam int CB_TRIG = 2;

  typedef struct packed {
    logic txPush;
    logic txFlush;
    logic rxPop;
    logic rxFlush;
  } fifoCmd_t;

endpackage

// File: rtl/i2c_word_fifo.sv
module i2c_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  pushData,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop;

  assign doPush = push && (count != CW'(DEPTH));
  assign doPop  = pop && (count != '0);
  assign head   = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= pushData;
  end

endmodule

// File: rtl/i2c_fifo_dpath.sv
module i2c_fifo_dpath
  import i2c_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCmd_t          cmd,
  input  logic [DATA_W-1:0] hostData,
  output logic              txValid,
  input  logic              txReady,
  output logic [DATA_W-1:0] txData,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] rxHead,
  output logic [CW-1:0]     txCount,
  output logic [CW-1:0]     rxCount
);

  assign txValid = (txCount != '0);
  assign rxReady = (rxCount != CW'(DEPTH));

  i2c_word_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .flush(cmd.txFlush),
    .push(cmd.txPush), .pushData(hostData),
    .pop(txValid && txReady), .head(txData), .count(txCount)
  );

  i2c_word_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .flush(cmd.rxFlush),
    .push(rxValid && rxReady), .pushData(rxData),
    .pop(cmd.rxPop), .head(rxHead), .count(rxCount)
  );

endmodule

// File: rtl/i2c_fifo_ctrl.sv
module i2c_fifo_ctrl
  import i2c_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int TRIG_W = 3,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int FW    = NIRQ
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [FW-1:0]     wrField,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] rxHead,
  input  logic [CW-1:0]     txCount,
  input  logic [CW-1:0]     rxCount,
  input  logic              evPktDone,
  input  logic              evAllDone,
  input  logic              evNack,
  input  logic              evArbLost,
  output fifoCmd_t          cmd,
  output logic [NIRQ-1:0]   statusQ,
  output logic [NIRQ-1:0]   maskQ
);

  regSel_e             sel;
  logic                txFlushQ, rxFlushQ;
  logic [TRIG_W-1:0]   txTrigQ, rxTrigQ;
  logic [CW-1:0]       txFree;
  logic                txFull, rxEmpty, txReq, rxReq;
  logic                wrCtrl, wrMask, wrIrq, wrTxd, rdRxd;
  logic [NIRQ-1:0]     setV, clrV, sticky;

  assign sel     = regSel_e'(regSel);
  assign wrCtrl  = wrEn && (sel == SEL_CTRL);
  assign wrMask  = wrEn && (sel == SEL_MASK);
  assign wrIrq   = wrEn && (sel == SEL_IRQ);
  assign wrTxd   = wrEn && (sel == SEL_TXD);
  assign rdRxd   = rdEn && (sel == SEL_RXD);

  assign txFree  = CW'(DEPTH) - txCount;
  assign txFull  = (txCount == CW'(DEPTH));
  assign rxEmpty = (rxCount == '0);
  assign txReq   = 32'(txFree)  >= 32'(txTrigQ) + 32'd1;
  assign rxReq   = 32'(rxCount) >= 32'(rxTrigQ) + 32'd1;

  always_comb begin
    cmd.txPush  = wrTxd && !txFull;
    cmd.rxPop   = rdRxd && !rxEmpty;
    cmd.txFlush = txFlushQ;
    cmd.rxFlush = rxFlushQ;
  end

  always_comb begin
    setV           = '0;
    setV[IB_PKT]   = evPktDone;
    setV[IB_ALL]   = evAllDone;
    setV[IB_OVF]   = wrTxd && txFull;
    setV[IB_UDF]   = rdRxd && rxEmpty;
    setV[IB_NACK]  = evNack;
    setV[IB_ARB]   = evArbLost;
    clrV           = wrIrq ? wrField : '0;
    sticky         = (statusQ & ~clrV) | setV;
    sticky[IB_TXRQ] = txReq;
    sticky[IB_RXRQ] = rxReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txFlushQ <= 1'b0;
      rxFlushQ <= 1'b0;
      txTrigQ  <= '0;
      rxTrigQ  <= '0;
      maskQ    <= '0;
      statusQ  <= '0;
    end else begin
      txFlushQ <= wrCtrl && wrField[CB_TXFL];
      rxFlushQ <= wrCtrl && wrField[CB_RXFL];
      if (wrCtrl) begin
        rxTrigQ <= wrField[CB_TRIG +: TRIG_W];
        txTrigQ <= wrField[CB_TRIG + TRIG_W +: TRIG_W];
      end
      if (wrMask) maskQ <= wrField;
      statusQ <= sticky;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdEn) begin
      case (sel)
        SEL_CTRL: rdData <= DATA_W'({txTrigQ, rxTrigQ, txFlushQ, rxFlushQ});
        SEL_OCC:  rdData <= DATA_W'({txFree, rxCount});
        SEL_MASK: rdData <= DATA_W'(maskQ);
        SEL_IRQ:  rdData <= DATA_W'(statusQ);
        SEL_RXD:  rdData <= rxEmpty ? '0 : rxHead;
        default:  rdData <= '0;
      endcase
    end
  end

endmodule

// File: rtl/i2c_fifo_irq_regs.sv
module i2c_fifo_irq_regs
  import i2c_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int TRIG_W = 3,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              txValid,
  input  logic              txReady,
  output logic [DATA_W-1:0] txData,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [DATA_W-1:0] rxData,
  input  logic              evPktDone,
  input  logic              evAllDone,
  input  logic              evNack,
  input  logic              evArbLost,
  output logic              irq
);

  fifoCmd_t          cmd;
  logic [DATA_W-1:0] rxHead;
  logic [CW-1:0]     txCount, rxCount;
  logic [NIRQ-1:0]   statusQ, maskQ;

  i2c_fifo_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .TRIG_W(TRIG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrField(wrData[NIRQ-1:0]), .rdData(rdData), .rxHead(rxHead),
    .txCount(txCount), .rxCount(rxCount),
    .evPktDone(evPktDone), .evAllDone(evAllDone), .evNack(evNack),
    .evArbLost(evArbLost), .cmd(cmd), .statusQ(statusQ), .maskQ(maskQ)
  );

  i2c_fifo_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .hostData(wrData),
    .txValid(txValid), .txReady(txReady), .txData(txData),
    .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData),
    .rxHead(rxHead), .txCount(txCount), .rxCount(rxCount)
  );

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |(statusQ & maskQ);
  end

endmodule

// File: rtl/i2c_fifo_chk.sv
module i2c_fifo_chk
  import i2c_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        regSel,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic              txValid,
  input logic              txReady,
  input logic [DATA_W-1:0] txData,
  input logic              rxReady,
  input logic              evPktDone,
  input logic              evNack,
  input logic              irq,
  input fifoCmd_t          cmd,
  input logic [CW-1:0]     txCount,
  input logic [CW-1:0]     rxCount,
  input logic [NIRQ-1:0]   statusQ,
  input logic [NIRQ-1:0]   maskQ
);

  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady && !cmd.txFlush |=> txValid && $stable(txData));

  // R4
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && regSel == SEL_TXD && txCount == CW'(DEPTH) |=> statusQ[IB_OVF]);

  // R5
  udf_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && regSel == SEL_RXD && rxCount == '0 |=> rdData == '0 && statusQ[IB_UDF]);

  // R6
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.txFlush |=> txCount == '0);

  // R6
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.rxFlush |=> rxCount == '0);

  // R10
  nack_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    evNack |=> statusQ[IB_NACK]);

  // R10
  pkt_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    evPktDone |=> statusQ[IB_PKT]);

  // R12
  mask_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    maskQ == '0 |=> !irq);

  // R12
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & maskQ) != '0 |=> irq);

  // R13
  rx_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxCount == CW'(DEPTH) |-> !rxReady);

endmodule

bind i2c_fifo_irq_regs i2c_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
  .rdData(rdData), .txValid(txValid), .txReady(txReady), .txData(txData),
  .rxReady(rxReady), .evPktDone(evPktDone), .evNack(evNack), .irq(irq),
  .cmd(cmd), .txCount(txCount), .rxCount(rxCount),
  .statusQ(statusQ), .maskQ(maskQ)
);

// File: tb/sim_i2c_fifo_irq_regs.sv
`timescale 1ns/1ps
module sim_i2c_fifo_irq_regs;
  import i2c_fifo_pkg::*;

  localparam int DW = 32;
  localparam int DEP = 8;

  logic clk = 1'b0;
  logic rstN;
  logic [2:0] regSel;
  logic wrEn, rdEn, txReady, rxValid;
  logic evPktDone, evAllDone, evNack, evArbLost;
  logic [DW-1:0] wrData, rxData, rdData, txData;
  logic txValid, rxReady, irq;

  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  i2c_fifo_irq_regs u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .txValid(txValid), .txReady(txReady),
    .txData(txData), .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData),
    .evPktDone(evPktDone), .evAllDone(evAllDone), .evNack(evNack),
    .evArbLost(evArbLost), .irq(irq)
  );

  function automatic logic [DW-1:0] txWord(int k);
    return 32'hC0DE_0000 | 32'(k * 17 + 3);
  endfunction
  function automatic logic [DW-1:0] rxWord(int k);
    return 32'hA5A5_0000 | 32'(k * 29 + 1);
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic hostWr(logic [2:0] s, logic [DW-1:0] d);
    regSel = s; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask
  task automatic hostRd(logic [2:0] s, output logic [DW-1:0] d);
    regSel = s; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask
  task automatic rdSettled(logic [2:0] s, output logic [DW-1:0] d);
    idle(3);
    hostRd(s, d);
  endtask
  task automatic rxPush(logic [DW-1:0] d);
    rxValid = 1'b1; rxData = d;
    @(negedge clk);
    rxValid = 1'b0;
  endtask
  task automatic txTake(logic [DW-1:0] exp);
    chk("R2 txValid", {31'b0, txValid}, 32'd1);
    chk("R2 txData order", txData, exp);
    txReady = 1'b1;
    @(negedge clk);
    txReady = 1'b0;
  endtask
  task automatic pulse(int b);
    case (b)
      IB_PKT:  evPktDone = 1'b1;
      IB_ALL:  evAllDone = 1'b1;
      IB_NACK: evNack    = 1'b1;
      default: evArbLost = 1'b1;
    endcase
    @(negedge clk);
    evPktDone = 1'b0; evAllDone = 1'b0; evNack = 1'b0; evArbLost = 1'b0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #(5ns * 100000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    logic [NIRQ-1:0] expSt;
    rstN = 1'b0; regSel = '0; wrEn = 0; rdEn = 0; wrData = '0;
    txReady = 0; rxValid = 0; rxData = '0;
    evPktDone = 0; evAllDone = 0; evNack = 0; evArbLost = 0;
    idle(4);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 txValid", {31'b0, txValid}, 32'd0);
    chk("R1 rxReady", {31'b0, rxReady}, 32'd1);
    rdSettled(SEL_OCC, v);  chk("R1 occupancy", v, 32'h80);
    rdSettled(SEL_MASK, v); chk("R1 mask", v, 32'h0);
    rdSettled(SEL_IRQ, v);  chk("R1/R8 status after reset", v, 32'h02);

    // R7 trigger field readback, all combinations
    for (int tt = 0; tt < 8; tt++)
      for (int rt = 0; rt < 8; rt++) begin
        hostWr(SEL_CTRL, 32'((tt << 5) | (rt << 2)));
        hostRd(SEL_CTRL, v);
        chk("R7 trigger readback", v, 32'((tt << 5) | (rt << 2)));
      end

    // R2/R8 transmit fill sweep against every trigger
    for (int n = 0; n <= DEP; n++) begin
      if (n > 0) hostWr(SEL_TXD, txWord(n - 1));
      rdSettled(SEL_OCC, v);
      chk("R2 free slots", v, 32'(((DEP - n) << 4)));
      for (int t = 0; t < 8; t++) begin
        hostWr(SEL_CTRL, 32'(t << 5));
        rdSettled(SEL_IRQ, v);
        chk("R8 tx request", {31'b0, v[IB_TXRQ]}, 32'((DEP - n) >= t + 1));
      end
      if (n == 3) begin
        hostWr(SEL_IRQ, 32'h02);
        rdSettled(SEL_IRQ, v);
        chk("R8 w1c ignored", {31'b0, v[IB_TXRQ]}, 32'((DEP - n) >= 8));
      end
    end

    // R4 overflow on a full transmit queue
    hostWr(SEL_TXD, 32'hDEAD_BEEF);
    rdSettled(SEL_IRQ, v);
    chk("R4 overflow bit", {31'b0, v[IB_OVF]}, 32'd1);
    rdSettled(SEL_OCC, v);
    chk("R4 free stays 0", v, 32'h00);
    hostWr(SEL_CTRL, 32'h0);
    for (int k = 0; k < DEP; k++) txTake(txWord(k));
    chk("R4 dropped word absent", {31'b0, txValid}, 32'd0);
    rdSettled(SEL_OCC, v);
    chk("R2 drained", v, 32'h80);

    // R3/R9/R13 receive fill sweep
    for (int m = 0; m <= DEP; m++) begin
      if (m > 0) rxPush(rxWord(m - 1));
      rdSettled(SEL_OCC, v);
      chk("R3 rx count", v, 32'h80 | 32'(m));
      for (int t = 0; t < 8; t++) begin
        hostWr(SEL_CTRL, 32'(t << 2));
        rdSettled(SEL_IRQ, v);
        chk("R9 rx request", {31'b0, v[IB_RXRQ]}, 32'(m >= t + 1));
      end
    end
    chk("R13 rxReady low when full", {31'b0, rxReady}, 32'd0);
    rxPush(32'h0BAD_0BAD);
    rdSettled(SEL_OCC, v);
    chk("R13 refused word", v, 32'h88);
    for (int k = 0; k < DEP; k++) begin
      hostRd(SEL_RXD, v);
      chk("R3 rx order", v, rxWord(k));
    end
    hostRd(SEL_RXD, v);
    chk("R5 empty read zero", v, 32'h0);
    rdSettled(SEL_IRQ, v);
    chk("R5 underflow bit", {31'b0, v[IB_UDF]}, 32'd1);

    // R10/R11 event latching and write-one-to-clear
    hostWr(SEL_CTRL, 32'h0);
    hostWr(SEL_IRQ, 32'hFF);
    rdSettled(SEL_IRQ, v);
    chk("R11 clear all", v, 32'h02);
    expSt = 8'h02;
    pulse(IB_PKT);  expSt[IB_PKT]  = 1'b1; rdSettled(SEL_IRQ, v); chk("R10 packet done", v, 32'(expSt));
    pulse(IB_ALL);  expSt[IB_ALL]  = 1'b1; rdSettled(SEL_IRQ, v); chk("R10 all done", v, 32'(expSt));
    pulse(IB_NACK); expSt[IB_NACK] = 1'b1; rdSettled(SEL_IRQ, v); chk("R10 nack", v, 32'(expSt));
    pulse(IB_ARB);  expSt[IB_ARB]  = 1'b1; rdSettled(SEL_IRQ, v); chk("R10 arbitration", v, 32'(expSt));
    hostWr(SEL_IRQ, 32'h40); expSt[IB_ALL] = 1'b0;
    rdSettled(SEL_IRQ, v); chk("R11 single clear", v, 32'(expSt));
    hostWr(SEL_IRQ, 32'h00);
    rdSettled(SEL_IRQ, v); chk("R11 zero write", v, 32'(expSt));
    hostWr(SEL_IRQ, 32'hFF);
    rdSettled(SEL_IRQ, v); chk("R11 clear all again", v, 32'h02);

    // R12 mask sweep against status 0xDE
    pulse(IB_PKT); pulse(IB_ALL); pulse(IB_NACK); pulse(IB_ARB);
    hostRd(SEL_RXD, v);
    rdSettled(SEL_IRQ, v);
    chk("R12 status pattern", v, 32'hDE);
    for (int mk = 0; mk < 256; mk++) begin
      hostWr(SEL_MASK, 32'(mk));
      idle(3);
      chk("R12 irq vs mask", {31'b0, irq}, 32'(|(8'(mk) & 8'hDE)));
    end
    hostWr(SEL_MASK, 32'h0);
    idle(3);
    chk("R12 zero mask", {31'b0, irq}, 32'd0);

    // R6 flush
    for (int k = 0; k < 3; k++) hostWr(SEL_TXD, txWord(k));
    rxPush(rxWord(0)); rxPush(rxWord(1));
    hostWr(SEL_CTRL, 32'h02);
    hostRd(SEL_CTRL, v);
    chk("R6 tx flush in progress", v, 32'h02);
    rdSettled(SEL_CTRL, v);
    chk("R6 tx flush done", v, 32'h00);
    rdSettled(SEL_OCC, v);
    chk("R6 tx emptied", v, 32'h82);
    chk("R6 txValid low", {31'b0, txValid}, 32'd0);
    rdSettled(SEL_IRQ, v);
    chk("R6 sticky kept", v, 32'hDF);
    hostWr(SEL_CTRL, 32'h01);
    hostRd(SEL_CTRL, v);
    chk("R6 rx flush in progress", v, 32'h01);
    rdSettled(SEL_OCC, v);
    chk("R6 rx emptied", v, 32'h80);
    rdSettled(SEL_IRQ, v);
    chk("R6 sticky kept rx", v, 32'hDE);

    report();
    $finish;
  end

endmodule